// File: doc/BRIEF.md
# Stack Machine Processor with Output Port

This block is a small multi-cycle processor that keeps all of its operands on an internal hardware stack. It has no register file. Programs and data live in one external single-port word memory. Each instruction takes two consecutive words: an operation code first, then an argument. The core fetches the two words, carries out the operation and moves the program counter on by two. Values reach the outside world through a valid/ready output port. They get there in one of two ways: an explicit output operation, or a store to one reserved address when the `MMIO_EN` parameter is set. When `MMIO_EN` is clear, that address is ordinary memory.

The core stops when the program counter reaches or passes the memory size. It also stops when the program misuses the stack. Stack misuse raises a sticky error flag as well. A jump takes its target from the stack, so a program ends cleanly by jumping to a value beyond the end of memory. Only a reset starts the core again.

Top module: `stk_proc`

## Requirements
- R1: After reset the output port is idle, `halted` and `err` are low, the stack is empty and the first memory read is issued at address 0.
- R2: Every instruction occupies two words (operation code at PC, argument at PC+1) and the PC grows by 2 after it; once PC ≥ `MEM_WORDS`, `halted` rises, stays high, and no further memory access is made.
- R3: Operation code 0 reads the memory word at the argument address and pushes it.
- R4: Operation code 1 pops the top of the stack and writes it to memory at the argument address.
- R5: Operation code 2 pops the top of the stack, and the PC becomes that value plus 2; its argument has no effect.
- R6: Operation code 3 pops two values and pushes their sum modulo 2^16; its argument has no effect.
- R7: Operation code 4 pops the top of the stack and presents it with `out_valid` high. `out_data` holds steady until `out_ready` is seen, and no memory access takes place while the transfer is pending.
- R8: With `MMIO_EN`=1, operation code 1 aimed at `MMIO_ADDR` (default 1000) sends the popped value to the output port instead of memory, and that memory word is left unchanged.
- R9: Popping with an empty stack (codes 1, 2, 4), or adding with fewer than two entries (code 3), sets `err`, halts the core and produces no output.
- R10: The stack holds exactly `DEPTH` (default 16) entries; pushing onto a full stack sets `err` and halts the core.
- R11: Operation codes 5 and above change nothing except the PC, which grows by 2.
- R12: Values leave the stack in the reverse of the order in which they were pushed.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| mem_addr | output | DW | Word address of the memory access |
| mem_rd_en | output | 1 | Read request; data is returned on `mem_rdata` one cycle later |
| mem_wr_en | output | 1 | Write request |
| mem_wdata | output | DW | Write data |
| mem_rdata | input | DW | Read data from the memory |
| out_valid | output | 1 | Output word is available |
| out_data | output | DW | Output word |
| out_ready | input | 1 | Consumer accepts the output word |
| halted | output | 1 | Core has stopped |
| err | output | 1 | Sticky stack-misuse flag |

## Verification
The hardest conditions to reach are the two stack boundaries. A full stack needs exactly sixteen pushes with no pop in between. An add with a single entry needs the stack to be left at one value on purpose. The stimulus builds these with programs of repeated loads, and it pairs the overflow case with a neighbouring program that touches the full depth without crossing it. Halting by running off the end of memory needs every word to decode as a no-op. So one program fills all of memory with an unassigned operation code and lets the core walk across it.

// File: rtl/stk_proc_pkg.sv
package stk_proc_pkg;

   typedef enum logic [2:0] {
      OP_LOAD  = 3'd0,
      OP_STORE = 3'd1,
      OP_JUMP  = 3'd2,
      OP_SUM   = 3'd3,
      OP_EMIT  = 3'd4,
      OP_NONE  = 3'd7
   } op_e;

   typedef enum logic [2:0] {
      ST_FETCH_OP,
      ST_FETCH_ARG,
      ST_EXEC,
      ST_LOAD_WB,
      ST_EMIT_WAIT,
      ST_STOP
   } state_e;

   localparam int unsigned OP_COUNT = 5;

endpackage

// File: rtl/stk_proc_stack.sv
module stk_proc_stack #(
   parameter int unsigned DW    = 16,
   parameter int unsigned DEPTH = 16
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          push_i,
   input  logic          pop_i,
   input  logic          fold_i,
   input  logic [DW-1:0] push_data_i,
   output logic [DW-1:0] top_o,
   output logic          empty_o,
   output logic          full_o,
   output logic          two_o
);
   localparam int unsigned CW = $clog2(DEPTH + 1);
   localparam int unsigned IW = $clog2(DEPTH);

   logic [CW-1:0] cnt_q;
   logic [CW-1:0] top_i;
   logic [CW-1:0] nxt_i;
   logic [CW-1:0] wr_i;
   logic [DW-1:0] wr_val;
   logic          wr_en;
   logic [DW-1:0] cells [DEPTH];
   logic [DW-1:0] nxt_val;

   assign top_i   = cnt_q - CW'(1);
   assign nxt_i   = cnt_q - CW'(2);
   assign top_o   = cells[top_i[IW-1:0]];
   assign nxt_val = cells[nxt_i[IW-1:0]];
   assign empty_o = (cnt_q == '0);
   assign full_o  = (cnt_q == CW'(DEPTH));
   assign two_o   = (cnt_q >= CW'(2));

   assign wr_en  = push_i | fold_i;
   assign wr_i   = push_i ? cnt_q : nxt_i;
   assign wr_val = push_i ? push_data_i : (top_o + nxt_val);

   for (genvar g = 0; g < DEPTH; g++) begin : g_cell
      logic [DW-1:0] cell_q;
      always_ff @(posedge clk) begin
         if (wr_en && (wr_i == CW'(g))) cell_q <= wr_val;
      end
      assign cells[g] = cell_q;
   end

   always_ff @(posedge clk) begin
      if (!rst_n)                 cnt_q <= '0;
      else if (push_i)            cnt_q <= cnt_q + CW'(1);
      else if (pop_i || fold_i)   cnt_q <= cnt_q - CW'(1);
   end

   AST_NO_OVERFLOW:  assert property (@(posedge clk) disable iff (!rst_n) push_i |-> !full_o);   // R10
   AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n) pop_i |-> !empty_o);   // R9
   AST_SUM_OPERANDS: assert property (@(posedge clk) disable iff (!rst_n) fold_i |-> two_o);     // R6
   AST_ONE_STK_OP:   assert property (@(posedge clk) disable iff (!rst_n)
                                      $onehot0({push_i, pop_i, fold_i}));                          // R12
endmodule

// File: rtl/stk_proc_outport.sv
module stk_proc_outport #(
   parameter int unsigned DW = 16
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load_i,
   input  logic [DW-1:0] data_i,
   input  logic          ready_i,
   output logic          valid_o,
   output logic [DW-1:0] data_o,
   output logic          taken_o
);
   assign taken_o = valid_o & ready_i;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         valid_o <= 1'b0;
         data_o  <= '0;
      end else if (load_i) begin
         valid_o <= 1'b1;
         data_o  <= data_i;
      end else if (taken_o) begin
         valid_o <= 1'b0;
      end
   end

   AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
                                  valid_o && !ready_i |=> valid_o && $stable(data_o));   // R7
   AST_NO_CLOBBER: assert property (@(posedge clk) disable iff (!rst_n)
                                    load_i |-> !valid_o);                                  // R7
endmodule

// File: rtl/stk_proc.sv
module stk_proc
   import stk_proc_pkg::*;
#(
   parameter int unsigned DW        = 16,
   parameter int unsigned DEPTH     = 16,
   parameter int unsigned MEM_WORDS = 1024,
   parameter bit          MMIO_EN   = 1'b1,
   parameter int unsigned MMIO_ADDR = 1000
) (
   input  logic          clk,
   input  logic          rst_n,
   output logic [DW-1:0] mem_addr,
   output logic          mem_rd_en,
   output logic          mem_wr_en,
   output logic [DW-1:0] mem_wdata,
   input  logic [DW-1:0] mem_rdata,
   output logic          out_valid,
   output logic [DW-1:0] out_data,
   input  logic          out_ready,
   output logic          halted,
   output logic          err
);
   localparam logic [DW-1:0] STEP = DW'(2);

   if (DW < 2 || DW > 32) begin : g_bad_dw
      $error("stk_proc: DW must lie in 2..32");
   end
   if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
      $error("stk_proc: DEPTH must be a power of two, at least 2");
   end
   if (MEM_WORDS < 2 || 64'(MEM_WORDS) > (64'd1 << DW)) begin : g_bad_mem
      $error("stk_proc: MEM_WORDS out of range for DW");
   end
   if (64'(MMIO_ADDR) >= (64'd1 << DW)) begin : g_bad_mmio
      $error("stk_proc: MMIO_ADDR not addressable");
   end

   state_e        st_q;
   op_e           op_q;
   logic [DW-1:0] pc_q;
   logic          err_q;
   logic          pc_past_end;
   logic          divert;

   logic          s_push, s_pop, s_fold;
   logic [DW-1:0] s_top;
   logic          s_empty, s_full, s_two;
   logic          o_load, o_taken;

   assign pc_past_end = (32'(pc_q) >= 32'(MEM_WORDS));

   if (MMIO_EN) begin : g_mmio
      assign divert = (mem_rdata == DW'(MMIO_ADDR));
   end else begin : g_no_mmio
      assign divert = 1'b0;
   end

   always_comb begin
      mem_addr  = pc_q;
      mem_rd_en = 1'b0;
      mem_wr_en = 1'b0;
      mem_wdata = s_top;
      s_push    = 1'b0;
      s_pop     = 1'b0;
      s_fold    = 1'b0;
      o_load    = 1'b0;
      unique case (st_q)
         ST_FETCH_OP:  mem_rd_en = !pc_past_end;
         ST_FETCH_ARG: begin
            mem_addr  = pc_q + DW'(1);
            mem_rd_en = 1'b1;
         end
         ST_EXEC: begin
            mem_addr = mem_rdata;
            unique case (op_q)
               OP_LOAD:  mem_rd_en = !s_full;
               OP_STORE: if (!s_empty) begin
                  s_pop     = 1'b1;
                  o_load    = divert;
                  mem_wr_en = !divert;
               end
               OP_JUMP:  s_pop  = !s_empty;
               OP_SUM:   s_fold = s_two;
               OP_EMIT:  if (!s_empty) begin
                  s_pop  = 1'b1;
                  o_load = 1'b1;
               end
               default: ;
            endcase
         end
         ST_LOAD_WB: s_push = 1'b1;
         default: ;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q  <= ST_FETCH_OP;
         op_q  <= OP_NONE;
         pc_q  <= '0;
         err_q <= 1'b0;
      end else begin
         unique case (st_q)
            ST_FETCH_OP:  st_q <= pc_past_end ? ST_STOP : ST_FETCH_ARG;
            ST_FETCH_ARG: begin
               op_q <= (32'(mem_rdata) < OP_COUNT) ? op_e'(mem_rdata[2:0]) : OP_NONE;
               st_q <= ST_EXEC;
            end
            ST_EXEC: begin
               unique case (op_q)
                  OP_LOAD: st_q <= s_full ? ST_STOP : ST_LOAD_WB;
                  OP_STORE: begin
                     if (s_empty)     st_q <= ST_STOP;
                     else if (divert) st_q <= ST_EMIT_WAIT;
                     else begin
                        pc_q <= pc_q + STEP;
                        st_q <= ST_FETCH_OP;
                     end
                  end
                  OP_JUMP: begin
                     pc_q <= s_top + STEP;
                     st_q <= s_empty ? ST_STOP : ST_FETCH_OP;
                  end
                  OP_SUM: begin
                     pc_q <= pc_q + STEP;
                     st_q <= s_two ? ST_FETCH_OP : ST_STOP;
                  end
                  OP_EMIT: st_q <= s_empty ? ST_STOP : ST_EMIT_WAIT;
                  default: begin
                     pc_q <= pc_q + STEP;
                     st_q <= ST_FETCH_OP;
                  end
               endcase
               if ((op_q == OP_LOAD && s_full) ||
                   (op_q == OP_SUM && !s_two) ||
                   ((op_q == OP_STORE || op_q == OP_JUMP || op_q == OP_EMIT) && s_empty))
                  err_q <= 1'b1;
            end
            ST_LOAD_WB: begin
               pc_q <= pc_q + STEP;
               st_q <= ST_FETCH_OP;
            end
            ST_EMIT_WAIT: if (o_taken) begin
               pc_q <= pc_q + STEP;
               st_q <= ST_FETCH_OP;
            end
            default: st_q <= ST_STOP;
         endcase
      end
   end

   assign halted = (st_q == ST_STOP);
   assign err    = err_q;

   stk_proc_stack #(.DW(DW), .DEPTH(DEPTH)) stack_i (
      .clk         (clk),
      .rst_n       (rst_n),
      .push_i      (s_push),
      .pop_i       (s_pop),
      .fold_i      (s_fold),
      .push_data_i (mem_rdata),
      .top_o       (s_top),
      .empty_o     (s_empty),
      .full_o      (s_full),
      .two_o       (s_two)
   );

   stk_proc_outport #(.DW(DW)) outport_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .load_i  (o_load),
      .data_i  (s_top),
      .ready_i (out_ready),
      .valid_o (out_valid),
      .data_o  (out_data),
      .taken_o (o_taken)
   );

   AST_HALT_STICKY: assert property (@(posedge clk) disable iff (!rst_n) halted |=> halted);          // R2
   AST_HALT_QUIET:  assert property (@(posedge clk) disable iff (!rst_n)
                                     halted |-> !mem_rd_en && !mem_wr_en);                              // R2
   AST_ERR_HALTS:   assert property (@(posedge clk) disable iff (!rst_n) err |-> halted);               // R9
   AST_STALL_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
                                     out_valid |-> !mem_rd_en && !mem_wr_en);                           // R7
   AST_MMIO_NO_WR:  assert property (@(posedge clk) disable iff (!rst_n)
                                     mem_wr_en |-> !(MMIO_EN && mem_addr == DW'(MMIO_ADDR)));           // R8
endmodule

// File: tb/stk_proc_tb.sv
module stk_proc_tb_top;
   localparam int MW = 1024;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [15:0] mem_addr, mem_wdata, out_data;
   logic [15:0] mem_rdata = '0;
   logic        mem_rd_en, mem_wr_en, out_valid, halted, err;
   logic        out_ready = 1'b1;

   logic [15:0] mem [MW];
   logic        tb_we = 1'b0, tb_clr = 1'b0;
   logic [15:0] tb_wa = '0, tb_wd = '0;
   logic [15:0] olog [64];
   int          on = 0;
   int          viol = 0;
   int          nchk = 0, nfail = 0;

   always #2.5 clk = ~clk;

   stk_proc dut_i (
      .clk(clk), .rst_n(rst_n), .mem_addr(mem_addr), .mem_rd_en(mem_rd_en),
      .mem_wr_en(mem_wr_en), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
      .out_valid(out_valid), .out_data(out_data), .out_ready(out_ready),
      .halted(halted), .err(err)
   );

   always @(posedge clk) begin
      if (tb_clr) begin
         for (int i = 0; i < MW; i++) mem[i] <= '0;
      end else if (tb_we) begin
         mem[tb_wa[9:0]] <= tb_wd;
      end else if (mem_wr_en && mem_addr < 16'(MW)) begin
         mem[mem_addr[9:0]] <= mem_wdata;
      end
      if (mem_rd_en) mem_rdata <= (mem_addr < 16'(MW)) ? mem[mem_addr[9:0]] : 16'h0;
   end

   always @(posedge clk) begin
      if (!rst_n) on <= 0;
      else if (out_valid && out_ready && on < 64) begin
         olog[on] <= out_data;
         on <= on + 1;
      end
      if (rst_n && out_valid && !out_ready && (mem_rd_en || mem_wr_en)) viol <= viol + 1;
   end

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      nchk++;
      if (!ok) begin
         nfail++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic wr(input int a, input int d);
      tb_wa = 16'(a); tb_wd = 16'(d); tb_we = 1'b1;
      @(negedge clk);
      tb_we = 1'b0;
   endtask

   task automatic ins(input int a, input int op, input int arg);
      wr(a, op);
      wr(a + 1, arg);
   endtask

   task automatic begin_prog();
      @(negedge clk);
      rst_n = 1'b0; out_ready = 1'b1; tb_clr = 1'b1;
      @(negedge clk);
      tb_clr = 1'b0;
   endtask

   task automatic go();
      @(negedge clk);
      rst_n = 1'b1;
   endtask

   task automatic run_to_halt(input string req);
      int n = 0;
      while (!halted && n < 8000) begin
         @(negedge clk);
         n++;
      end
      chk(halted, req, int'(halted), 1);
   endtask

   task automatic hello_words();
      wr(24, 111); wr(25, 108); wr(26, 108); wr(27, 101); wr(28, 72); wr(29, 10000);
   endtask

   task automatic hello_check(input string req);
      int exp [5] = '{72, 101, 108, 108, 111};
      chk(on == 5, req, on, 5);
      for (int i = 0; i < 5; i++) chk(olog[i] == 16'(exp[i]), req, olog[i], exp[i]);
   endtask

   task automatic t_reset();
      begin_prog();
      go();
      chk(!out_valid && !halted && !err, "R1", {out_valid, halted, err}, 0);
      chk(mem_rd_en && mem_addr == 0, "R1", mem_addr, 0);
   endtask

   task automatic t_add();
      begin_prog();
      ins(0, 0, 12); ins(2, 0, 13); ins(4, 3, 0); ins(6, 1, 14); ins(8, 0, 15); ins(10, 2, 0);
      wr(12, 40); wr(13, 2); wr(15, 10000);
      go();
      run_to_halt("R2");
      chk(mem[14] == 16'd42, "R3 R4 R6", mem[14], 42);
      chk(!err, "R2", err, 0);
   endtask

   task automatic t_wrap();
      begin_prog();
      ins(0, 0, 10); ins(2, 0, 11); ins(4, 3, 77); ins(6, 1, 12); ins(8, 0, 13); ins(14, 0, 0);
      ins(10, 2, 0);
      wr(10, 16'hFFF0); wr(11, 16'h0020); wr(13, 10000);
      go();
      run_to_halt("R6");
      chk(mem[12] == 16'h0010, "R6", mem[12], 16'h0010);
   endtask

   task automatic t_hello_port();
      begin_prog();
      for (int i = 0; i < 5; i++) ins(2 * i, 0, 24 + i);
      for (int i = 5; i < 10; i++) ins(2 * i, 4, 0);
      ins(20, 0, 29); ins(22, 2, 0);
      hello_words();
      go();
      run_to_halt("R7");
      hello_check("R7 R12");
   endtask

   task automatic t_hello_mmio();
      begin_prog();
      for (int i = 0; i < 5; i++) ins(2 * i, 0, 24 + i);
      for (int i = 5; i < 10; i++) ins(2 * i, 1, 1000);
      ins(20, 0, 29); ins(22, 2, 0);
      hello_words();
      go();
      run_to_halt("R8");
      hello_check("R8 R12");
      chk(mem[1000] == 16'd0, "R8", mem[1000], 0);
   endtask

   task automatic t_stall();
      int v0;
      int n = 0;
      begin_prog();
      ins(0, 0, 8); ins(2, 4, 0); ins(4, 0, 9); ins(6, 2, 0);
      wr(8, 16'hBEEF); wr(9, 10000);
      out_ready = 1'b0;
      go();
      while (!out_valid && n < 50) begin
         @(negedge clk);
         n++;
      end
      v0 = viol;
      repeat (10) @(negedge clk);
      chk(out_valid && out_data == 16'hBEEF, "R7", out_data, 16'hBEEF);
      chk(!halted, "R7", halted, 0);
      out_ready = 1'b1;
      run_to_halt("R7");
      chk(viol == v0, "R7", viol, v0);
      chk(on == 1 && olog[0] == 16'hBEEF, "R7", olog[0], 16'hBEEF);
   endtask

   task automatic t_jump();
      begin_prog();
      ins(0, 0, 20); ins(2, 2, 99); ins(4, 0, 21); ins(6, 1, 30);
      ins(8, 0, 22); ins(10, 1, 31); ins(12, 0, 23); ins(14, 2, 0);
      wr(20, 6); wr(21, 16'h77); wr(22, 16'h55); wr(23, 10000);
      go();
      run_to_halt("R5");
      chk(mem[30] == 16'd0, "R5", mem[30], 0);
      chk(mem[31] == 16'h55, "R5", mem[31], 16'h55);
      chk(!err, "R5", err, 0);
   endtask

   task automatic t_under(input int op, input bit preload);
      begin_prog();
      if (preload) begin
         ins(0, 0, 10); ins(2, op, 40);
      end else begin
         ins(0, op, 40);
      end
      wr(10, 5);
      go();
      run_to_halt("R9");
      chk(err, "R9", err, 1);
      chk(on == 0, "R9", on, 0);
   endtask

   task automatic t_depth(input bit over);
      begin_prog();
      if (over) begin
         for (int i = 0; i < 17; i++) ins(2 * i, 0, 40);
      end else begin
         for (int i = 0; i < 16; i++) ins(2 * i, 0, 40);
         ins(32, 1, 60); ins(34, 0, 50); ins(36, 2, 0);
      end
      wr(40, 16'h1234); wr(50, 10000);
      go();
      run_to_halt("R10");
      chk(err == over, "R10", err, int'(over));
      if (!over) chk(mem[60] == 16'h1234, "R10", mem[60], 16'h1234);
   endtask

   task automatic t_unknown();
      begin_prog();
      ins(0, 7, 5); ins(2, 0, 10); ins(4, 4, 0); ins(6, 0, 11); ins(8, 2, 0);
      wr(10, 16'h0ABC); wr(11, 10000);
      go();
      run_to_halt("R11");
      chk(on == 1 && olog[0] == 16'h0ABC, "R11", olog[0], 16'h0ABC);
      chk(!err, "R11", err, 0);
   endtask

   task automatic t_run_off();
      begin_prog();
      for (int i = 0; i < MW; i++) wr(i, 5);
      go();
      run_to_halt("R2");
      chk(!err && on == 0, "R2", err, 0);
      @(negedge clk);
      chk(!mem_rd_en && !mem_wr_en, "R2", mem_rd_en, 0);
   endtask

   initial begin
      #750000;
      nfail++;
      nchk++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("%0d/%0d checks passed", nchk - nfail, nchk);
      $finish;
   end

   initial begin
      t_reset();
      t_add();
      t_wrap();
      t_hello_port();
      t_hello_mmio();
      t_stall();
      t_jump();
      t_under(3, 1'b0);
      t_under(3, 1'b1);
      t_under(4, 1'b0);
      t_under(2, 1'b0);
      t_under(1, 1'b0);
      t_depth(1'b0);
      t_depth(1'b1);
      t_unknown();
      t_run_off();
      $display("%0d/%0d checks passed", nchk - nfail, nchk);
      $finish;
   end
endmodule